// File: doc/BRIEF.md
# PCI-to-ISA Interrupt Router

This block takes level-sensitive interrupt sources and steers each one onto one of sixteen ISA interrupt request lines. There are seven sources: four external PCI interrupt pins (A to D) and the interrupts of three internal functions (functions 2, 3 and 5). Every source owns one bit in a 16-bit source-state word. Function f uses bit f, and external pin p (A=0 to D=3) uses bit 8+p. Each ISA line keeps a 16-bit bitmap of the sources that were routed to it and are still asserted. The line is driven high while that bitmap is non-zero.

The routing of each pin comes from a 4-bit field in one of three configuration bytes. The routing of each internal function comes from that function's own 8-bit interrupt-line value. A source looks up its route only when its level changes. After every update, each line bitmap is masked with the source-state word. As a result, a source whose route was reprogrammed while it was asserted never leaves a stuck bit on its old line once it deasserts. A target value that names no usable line raises a one-cycle error flag.

Top module: `pci_isa_irq_router`

## Requirements
- R1: While `rst_n` is low, and at the first sample after its release, `isa_irq` is all zeros and `route_err` is 0. A source that is high when reset releases counts as a fresh rising edge.
- R2: Pin routes come from nibbles: pin A from `cfg_sel0[7:4]`, pin B from `cfg_sel1[3:0]`, pin C from `cfg_sel1[7:4]`, pin D from `cfg_sel2[7:4]`. The nibbles `cfg_sel0[3:0]` and `cfg_sel2[3:0]` have no effect.
- R3: Function sources route by their interrupt-line byte in `fn_line`: bits [7:0] for function 2, [15:8] for function 3, [23:16] for function 5.
- R4: A level change sampled at a rising clock edge is visible on `isa_irq` and `route_err` right after that same edge. Before the edge, the outputs keep their old values.
- R5: An ISA line is the OR of all sources that were routed to it at their rising edge and are still high. A line shared by two sources stays high until the last of them drops.
- R6: A target of 0x00 or 0xFF disables the source: it drives no line and raises no error.
- R7: A target above 15, or equal to 2, is invalid. The source drives no line, and `route_err` is high for exactly the one cycle after each edge of that source.
- R8: A source reads its route only at its own edges. Reprogramming the route while the source is high does not move it. When it then falls, its old line drops (no stale bit), and its next rise uses the new route.
- R9: ISA lines 0 and 2 never assert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | 4 | External pin levels, bit 0 = pin A ... bit 3 = pin D |
| fn_lvl | input | 3 | Internal function levels, bit 0 = function 2, bit 1 = function 3, bit 2 = function 5 |
| cfg_sel0 | input | 8 | Route byte holding pin A's target in [7:4] |
| cfg_sel1 | input | 8 | Route byte holding pin B in [3:0] and pin C in [7:4] |
| cfg_sel2 | input | 8 | Route byte holding pin D's target in [7:4] |
| fn_line | input | 24 | Interrupt-line bytes of functions 2, 3 and 5 (low byte first) |
| isa_irq | output | 16 | Registered ISA interrupt request lines |
| route_err | output | 1 | One-cycle flag for an edge on a source with an invalid target |

## Verification
The assertions check properties that must hold on every cycle:
- the source-state word tracks the previous cycle's input levels;
- lines 0 and 2 stay low;
- an error pulse always follows a source edge;
- the lines cannot change on a cycle with no source edge;
- all lines are low once every source has been low.

The per-line routing itself can only be shown by the bench's scenarios. These include the exact nibble and byte decode for every target value, and the moment a line asserts. They also cover which of two shared sources holds a line, the behaviour of a source whose route changed while it was asserted, and reset taken while a source is high.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int unsigned NUM_LINES = 16;
    localparam int unsigned LINE_W    = $clog2(NUM_LINES);
    localparam int unsigned SRC_W     = 16;
    localparam int unsigned SRC_IDX_W = $clog2(SRC_W);
    localparam int unsigned NUM_FUNCS = 3;
    localparam int unsigned NUM_PINS  = 4;
    localparam int unsigned NUM_SRC   = NUM_FUNCS + NUM_PINS;
    localparam int unsigned PIN_BASE  = 8;
    localparam int unsigned TGT_W     = 8;
    localparam int unsigned CASCADE   = 2;
    localparam logic [TGT_W-1:0] TGT_OFF_LO = '0;
    localparam logic [TGT_W-1:0] TGT_OFF_HI = '1;

    typedef logic [TGT_W-1:0] tgt_t;

    typedef struct packed {
        logic              used;
        logic              bad;
        logic [LINE_W-1:0] line;
    } route_t;

    // Source index s: 0..NUM_FUNCS-1 are functions 2,3,5; the rest are pins A..D.
    function automatic logic [SRC_IDX_W-1:0] src_bit(input int s);
        logic [SRC_IDX_W-1:0] b;
        if (s == 0)                   b = SRC_IDX_W'(2);
        else if (s == 1)              b = SRC_IDX_W'(3);
        else if (s == 2)              b = SRC_IDX_W'(5);
        else                          b = SRC_IDX_W'(PIN_BASE + s - NUM_FUNCS);
        return b;
    endfunction

    function automatic route_t classify(input tgt_t t);
        route_t r;
        r = '0;
        r.line = t[LINE_W-1:0];
        if (t == TGT_OFF_LO || t == TGT_OFF_HI) begin
            r.used = 1'b0;
        end else if (t > tgt_t'(NUM_LINES - 1) || t == tgt_t'(CASCADE)) begin
            r.bad = 1'b1;
        end else begin
            r.used = 1'b1;
        end
        return r;
    endfunction

    function automatic tgt_t pin_target(input int p, input logic [7:0] s0,
                                        input logic [7:0] s1, input logic [7:0] s2);
        tgt_t t;
        case (p)
            0:       t = {4'h0, s0[7:4]};
            1:       t = {4'h0, s1[3:0]};
            2:       t = {4'h0, s1[7:4]};
            default: t = {4'h0, s2[7:4]};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
    import irq_router_pkg::*;
(
    input  logic [7:0]                 cfg_sel0_i,
    input  logic [7:0]                 cfg_sel1_i,
    input  logic [7:0]                 cfg_sel2_i,
    input  logic [NUM_FUNCS*TGT_W-1:0] fn_line_i,
    output route_t [NUM_SRC-1:0]       routes_o
);

    logic unused_nib;
    assign unused_nib = ^{cfg_sel0_i[3:0], cfg_sel2_i[3:0]};

    for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
        assign routes_o[f] = classify(fn_line_i[f*TGT_W +: TGT_W]);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        assign routes_o[NUM_FUNCS + p] =
            classify(pin_target(p, cfg_sel0_i, cfg_sel1_i, cfg_sel2_i));
    end

endmodule

// File: rtl/irq_source_track.sv
module irq_source_track
    import irq_router_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] lvl_i,
    output logic [NUM_SRC-1:0] chg_o,
    output logic [SRC_W-1:0]   glob_d_o
);

    typedef struct packed {
        logic [SRC_W-1:0] glob;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        chg_o = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            chg_o[s] = lvl_i[s] ^ trk_q.glob[src_bit(s)];
            trk_d.glob[src_bit(s)] = lvl_i[s];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign glob_d_o = trk_d.glob;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
        // R4: each state bit equals the level sampled at the previous edge
        assert_state_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> trk_q.glob[src_bit(s)] == $past(lvl_i[s]));
    end

endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
    import irq_router_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_SRC-1:0]    lvl_i,
    input  logic [NUM_SRC-1:0]    chg_i,
    input  route_t [NUM_SRC-1:0]  routes_i,
    input  logic [SRC_W-1:0]      glob_d_i,
    output logic [NUM_LINES-1:0]  irq_o,
    output logic                  err_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0][SRC_W-1:0] bm;
        logic [NUM_LINES-1:0]            irq;
        logic                            err;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d     = map_q;
        map_d.err = 1'b0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (chg_i[s]) begin
                if (routes_i[s].bad) begin
                    map_d.err = 1'b1;
                end else if (routes_i[s].used) begin
                    map_d.bm[routes_i[s].line][src_bit(s)] = lvl_i[s];
                end
            end
        end
        for (int i = 0; i < NUM_LINES; i++) begin
            map_d.bm[i]  = map_d.bm[i] & glob_d_i;
            map_d.irq[i] = |map_d.bm[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign irq_o = map_q.irq;
    assign err_o = map_q.err;

    // R9: the cascade line and line 0 are never driven
    assert_no_cascade_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o[CASCADE] && !irq_o[0]);

    // R7: an error pulse is always preceded by a source edge
    assert_err_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && err_o) |-> $past(|chg_i));

    // R8: without any source edge the lines hold
    assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i == '0) |=> $stable(irq_o));

endmodule

// File: rtl/pci_isa_irq_router.sv
module pci_isa_irq_router
    import irq_router_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PINS-1:0]        pin_lvl,
    input  logic [NUM_FUNCS-1:0]       fn_lvl,
    input  logic [7:0]                 cfg_sel0,
    input  logic [7:0]                 cfg_sel1,
    input  logic [7:0]                 cfg_sel2,
    input  logic [NUM_FUNCS*TGT_W-1:0] fn_line,
    output logic [NUM_LINES-1:0]       isa_irq,
    output logic                       route_err
);

    logic [NUM_SRC-1:0]   lvl;
    logic [NUM_SRC-1:0]   chg;
    logic [SRC_W-1:0]     glob_d;
    route_t [NUM_SRC-1:0] routes;

    assign lvl = {pin_lvl, fn_lvl};

    irq_route_decode u_decode (
        .cfg_sel0_i (cfg_sel0),
        .cfg_sel1_i (cfg_sel1),
        .cfg_sel2_i (cfg_sel2),
        .fn_line_i  (fn_line),
        .routes_o   (routes)
    );

    irq_source_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl),
        .chg_o    (chg),
        .glob_d_o (glob_d)
    );

    irq_line_map u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_i    (lvl),
        .chg_i    (chg),
        .routes_i (routes),
        .glob_d_i (glob_d),
        .irq_o    (isa_irq),
        .err_o    (route_err)
    );

    // R5: with every source low, every line is low after the edge
    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_lvl == '0 && fn_lvl == '0) |=> (isa_irq == '0));

endmodule

// File: tb/tb_pci_isa_irq_router.sv
module tb_pci_isa_irq_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  pin_lvl = '0;
    logic [2:0]  fn_lvl = '0;
    logic [7:0]  cfg_sel0 = '0, cfg_sel1 = '0, cfg_sel2 = '0;
    logic [23:0] fn_line = '0;
    logic [15:0] isa_irq;
    logic        route_err;

    always #10 clk = ~clk;

    pci_isa_irq_router dut (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .fn_lvl(fn_lvl),
        .cfg_sel0(cfg_sel0), .cfg_sel1(cfg_sel1), .cfg_sel2(cfg_sel2),
        .fn_line(fn_line), .isa_irq(isa_irq), .route_err(route_err)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    logic [6:0]  m_lvl = '0;
    bit          m_on[7];
    int          m_tgt[7];
    logic [15:0] e_irq = '0;
    logic        e_err = 1'b0;

    function automatic int tgt_of(int s);
        case (s)
            0, 1, 2: return int'(fn_line[8*s +: 8]);
            3:       return int'(cfg_sel0[7:4]);
            4:       return int'(cfg_sel1[3:0]);
            5:       return int'(cfg_sel1[7:4]);
            default: return int'(cfg_sel2[7:4]);
        endcase
    endfunction

    task automatic model_reset();
        m_lvl = '0;
        for (int s = 0; s < 7; s++) begin m_on[s] = 0; m_tgt[s] = 0; end
        e_irq = '0;
        e_err = 1'b0;
    endtask

    task automatic model_step(input logic [3:0] p, input logic [2:0] f);
        logic [6:0] nv;
        nv = {p, f};
        e_err = 1'b0;
        for (int s = 0; s < 7; s++) begin
            if (nv[s] != m_lvl[s]) begin
                int  t;
                bit  off, inv;
                t   = tgt_of(s);
                off = (t == 0) || (t == 255);
                inv = !off && (t > 15 || t == 2);
                if (inv) e_err = 1'b1;
                if (nv[s]) begin
                    m_on[s]  = !off && !inv;
                    m_tgt[s] = t;
                end else begin
                    m_on[s] = 0;
                end
            end
        end
        m_lvl = nv;
        e_irq = '0;
        for (int s = 0; s < 7; s++) if (m_on[s]) e_irq[m_tgt[s]] = 1'b1;
    endtask

    task automatic check(input string tag);
        checks++;
        if (isa_irq !== e_irq || route_err !== e_err) begin
            fails++;
            $display("FAIL %s: isa_irq=%h route_err=%b expected isa_irq=%h route_err=%b",
                     tag, isa_irq, route_err, e_irq, e_err);
        end
    endtask

    // Apply levels at a falling edge; the result is sampled one falling edge later.
    task automatic drive(input logic [3:0] p, input logic [2:0] f, input string tag);
        model_step(p, f);
        pin_lvl = p;
        fn_lvl  = f;
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    function automatic string tag_for(int t, string base);
        if (t == 0 || t == 255) return "R6";
        if (t > 15 || t == 2)   return "R7";
        return base;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");

        // R2 / R9: every nibble value for every pin, with the unused nibbles busy
        for (int p = 0; p < 4; p++) begin
            for (int t = 0; t < 16; t++) begin
                cfg_sel0 = 8'hA5; cfg_sel1 = 8'hAA; cfg_sel2 = 8'hA5;
                case (p)
                    0: cfg_sel0[7:4] = 4'(t);
                    1: cfg_sel1[3:0] = 4'(t);
                    2: cfg_sel1[7:4] = 4'(t);
                    default: cfg_sel2[7:4] = 4'(t);
                endcase
                cfg_sel0[3:0] = 4'(15 - t);
                cfg_sel2[3:0] = 4'(t + 3);
                drive(4'(1 << p), 3'b000, tag_for(t, "R2"));
                drive(4'b0000, 3'b000, tag_for(t, "R9"));
            end
        end

        // R3 / R6 / R7: every byte value for every internal function
        for (int f = 0; f < 3; f++) begin
            for (int t = 0; t < 256; t++) begin
                fn_line = 24'h030303;
                fn_line[8*f +: 8] = 8'(t);
                drive(4'b0000, 3'(1 << f), tag_for(t, "R3"));
                drive(4'b0000, 3'b000, tag_for(t, "R3"));
            end
        end

        // R4: outputs hold before the sampling edge and change right after it
        cfg_sel0 = 8'h90;
        @(negedge clk);
        model_step(4'b0001, 3'b000);
        pin_lvl = 4'b0001;
        #2;
        checks++;
        if (isa_irq !== 16'h0000) begin
            fails++;
            $display("FAIL R4: isa_irq=%h before edge, expected 0000", isa_irq);
        end
        @(posedge clk);
        @(negedge clk);
        check("R4");
        drive(4'b0000, 3'b000, "R4");

        // R5: two pins sharing line 9
        cfg_sel0 = 8'h90; cfg_sel1 = 8'h09;
        drive(4'b0001, 3'b000, "R5");
        drive(4'b0011, 3'b000, "R5");
        drive(4'b0010, 3'b000, "R5");
        drive(4'b0000, 3'b000, "R5");

        // R8: route change while asserted, then fall, then rise on the new line
        fn_line = 24'h000004;
        drive(4'b0000, 3'b001, "R8");
        fn_line = 24'h000006;
        drive(4'b0000, 3'b001, "R8");
        drive(4'b0000, 3'b000, "R8");
        drive(4'b0000, 3'b001, "R8");
        fn_line = 24'h000020;
        drive(4'b0000, 3'b000, "R7");
        drive(4'b0000, 3'b000, "R7");

        // R1: reset taken while a source is high
        fn_line = 24'h000007;
        drive(4'b0000, 3'b001, "R1");
        rst_n = 1'b0;
        #2;
        model_reset();
        check("R1");
        @(negedge clk);
        rst_n = 1'b1;
        drive(4'b0000, 3'b001, "R1");
        drive(4'b0000, 3'b000, "R1");

        // R5 / R8: random levels and routes against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 4'h0) begin
                cfg_sel0 = 8'($urandom); cfg_sel1 = 8'($urandom);
                cfg_sel2 = 8'($urandom);
                fn_line  = {4'h0, 4'($urandom), 4'h0, 4'($urandom), 4'h0, 4'($urandom)};
            end
            drive(r[11:8], r[14:12], "R5");
        end
        drive(4'b0000, 3'b000, "R5");

        finish_run();
    end

endmodule